// File: doc/BRIEF.md
# Code-Density Histogram Engine

This block collects a histogram of converter output codes while a sine wave (or any other stimulus) drives the converter under test. Each code that arrives with its valid strobe is mapped to one of 1024 bins by dropping its least significant bit. The bin counts live in an internal memory that maps onto block RAM. Next to the histogram the block keeps running statistics: how many samples arrived, how many fell outside the bin range, and the lowest and highest bins that have been hit.

A start command sweeps the memory to zero and clears the statistics. Acquisition then runs until a stop command. After stop the block walks the occupied span, from the lowest hit bin to the highest, and streams one triple per cycle: the bin number, its count, and the count accumulated since the start of the span. A one-cycle done pulse closes the stream. Downstream logic or software divides the accumulated counts by the sample total to form linearity figures. That arithmetic lies outside this block.

Top module: `code_hist_engine`

## Requirements
- R1: After reset is released, and after any start pulse, `busy` stays high for exactly 1024 cycles while every bin is written to zero. When `busy` falls, `total_cnt`, `oor_cnt` and `any_hit` read zero.
- R2: `in_code` is a 13-bit two's-complement value. Its bin index is the code arithmetically shifted right by one, so codes 2k and 2k+1 land in the same bin k.
- R3: A code whose shifted value is below 0 or above 1023 (raw code below 0 or above 2047) updates no bin and increments `oor_cnt` by one. Raw codes 0 and 2047 are in range.
- R4: `total_cnt` increments by one for every accepted sample, whether in range or not, one cycle after the sample is presented.
- R5: A sample is accepted only in the acquisition phase, which begins when `busy` falls and ends with the cycle in which `stop` is high. `in_valid` while `busy` is high, during readout, or after readout has no effect on any count.
- R6: Samples presented on consecutive cycles to the same bin each add one to that bin, with no count lost.
- R7: A bin count saturates at its all-ones value (63 with the bench's 6-bit counters) and never wraps to zero.
- R8: `min_bin` and `max_bin` give the lowest and highest bin that holds at least one in-range sample, and `any_hit` is high once such a sample exists.
- R9: After `stop`, the block asserts `rd_valid` for exactly `max_bin - min_bin + 1` consecutive cycles. The triples are emitted in ascending bin order and include empty bins inside the span. `rd_cum` equals the sum of `rd_count` over all bins from `min_bin` up to and including the current bin.
- R10: `rd_done` pulses high for one cycle, on the cycle after the last triple. If no in-range sample was seen, `rd_done` pulses and no triple is emitted.
- R11: A start pulse during acquisition or readout abandons that work at once and begins a fresh clear. No count from before the pulse survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin clear, then acquisition |
| stop | input | 1 | End acquisition and begin readout |
| in_valid | input | 1 | Code strobe |
| in_code | input | 13 | Signed converter code |
| busy | output | 1 | Memory clear in progress |
| total_cnt | output | 32 | Accepted samples |
| oor_cnt | output | 32 | Accepted samples outside the bin range |
| any_hit | output | 1 | At least one bin occupied |
| min_bin | output | 10 | Lowest occupied bin |
| max_bin | output | 10 | Highest occupied bin |
| rd_valid | output | 1 | Readout triple valid |
| rd_bin | output | 10 | Readout bin number |
| rd_count | output | 24 | Count of that bin |
| rd_cum | output | 32 | Accumulated count from min_bin to this bin |
| rd_done | output | 1 | Readout finished pulse |

## Verification
Directed codes at both edges of the range (0, 1, 2047, 2048, -1, -4096) and pairs such as 4 and 5 separate the shift mapping from the range test. Bursts on one bin on consecutive cycles expose a read-modify-write hazard that spaced samples would hide. A long burst past the counter limit separates saturation from wrap. Seeded random codes with random gaps, some out of range, fill a wide span with empty holes. This tests ordering, the accumulated sum and span limits during readout. An empty run and a restart in the middle of acquisition separate the no-hit path and the abort path from normal completion.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR = 3'd0,
    ST_ACQ   = 3'd1,
    ST_DRAIN = 3'd2,
    ST_READ  = 3'd3,
    ST_IDLE  = 3'd4
  } eng_state_t;
endpackage

// File: rtl/hist_bin_ram.sv
module hist_bin_ram #(
  parameter int AW = 10,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hist_update.sv
module hist_update #(
  parameter int BIN_W = 10,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             in_v,
  input  logic [BIN_W-1:0] in_idx,
  input  logic [CNT_W-1:0] ram_rdata,
  output logic [BIN_W-1:0] ram_raddr,
  output logic             we,
  output logic [BIN_W-1:0] waddr,
  output logic [CNT_W-1:0] wdata
);
  logic             p1_v, p2_v, w_v;
  logic [BIN_W-1:0] p1_idx, p2_idx, w_idx;
  logic [CNT_W-1:0] w_data;
  logic [CNT_W-1:0] base, nxt;

  // The write retiring on the same edge as a read is invisible to it: forward it.
  always_comb begin
    base = (w_v && (w_idx == p2_idx)) ? w_data : ram_rdata;
    nxt  = (&base) ? base : base + CNT_W'(1);
  end

  assign ram_raddr = p1_idx;
  assign we        = p2_v;
  assign waddr     = p2_idx;
  assign wdata     = nxt;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      p1_v <= 1'b0;
      p2_v <= 1'b0;
      w_v  <= 1'b0;
    end else begin
      p1_v <= in_v;
      p2_v <= p1_v;
      w_v  <= p2_v;
    end
    p1_idx <= in_idx;
    p2_idx <= p1_idx;
    w_idx  <= p2_idx;
    w_data <= nxt;
  end

  AST_INC_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
    we |-> (wdata != '0)); // R7

  AST_FWD_MONOTONIC: assert property (@(posedge clk) disable iff (rst || flush)
    (we && w_v && (waddr == w_idx)) |-> (wdata >= w_data)); // R6
endmodule

// File: rtl/hist_stats.sv
module hist_stats #(
  parameter int BIN_W = 10,
  parameter int TOT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             acc,
  input  logic             in_range,
  input  logic [BIN_W-1:0] idx,
  output logic [TOT_W-1:0] total,
  output logic [TOT_W-1:0] oor,
  output logic             any,
  output logic [BIN_W-1:0] min_idx,
  output logic [BIN_W-1:0] max_idx
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      total   <= '0;
      oor     <= '0;
      any     <= 1'b0;
      min_idx <= '0;
      max_idx <= '0;
    end else if (acc) begin
      total <= total + TOT_W'(1);
      if (!in_range) begin
        oor <= oor + TOT_W'(1);
      end else if (!any) begin
        any     <= 1'b1;
        min_idx <= idx;
        max_idx <= idx;
      end else begin
        if (idx < min_idx) min_idx <= idx;
        if (idx > max_idx) max_idx <= idx;
      end
    end
  end

  AST_MIN_LE_MAX: assert property (@(posedge clk) disable iff (rst)
    any |-> (min_idx <= max_idx)); // R8

  AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((total == $past(total)) || (total == $past(total) + TOT_W'(1)))); // R4

  AST_OOR_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    oor <= total); // R3
endmodule

// File: rtl/hist_readout.sv
module hist_readout #(
  parameter int BIN_W = 10,
  parameter int CNT_W = 24,
  parameter int TOT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             go,
  input  logic             any,
  input  logic [BIN_W-1:0] min_idx,
  input  logic [BIN_W-1:0] max_idx,
  input  logic [CNT_W-1:0] ram_rdata,
  output logic [BIN_W-1:0] ram_raddr,
  output logic             rd_valid,
  output logic [BIN_W-1:0] rd_bin,
  output logic [CNT_W-1:0] rd_count,
  output logic [TOT_W-1:0] rd_cum,
  output logic             rd_done
);
  logic             active;
  logic [BIN_W-1:0] ptr;
  logic             s_v, s_last, o_last;
  logic [BIN_W-1:0] s_bin;
  logic [TOT_W-1:0] cum, sum;

  assign ram_raddr = ptr;
  assign sum       = cum + TOT_W'(ram_rdata);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      active   <= 1'b0;
      s_v      <= 1'b0;
      s_last   <= 1'b0;
      rd_valid <= 1'b0;
      o_last   <= 1'b0;
      rd_done  <= 1'b0;
      cum      <= '0;
    end else begin
      s_v    <= active;
      s_last <= active && (ptr == max_idx);
      if (go) begin
        active <= any;
        ptr    <= min_idx;
        cum    <= '0;
        if (!any) s_last <= 1'b1;
      end else if (active) begin
        if (ptr == max_idx) active <= 1'b0;
        else ptr <= ptr + BIN_W'(1);
      end
      rd_valid <= s_v;
      o_last   <= s_last;
      rd_done  <= o_last;
      if (s_v) begin
        cum    <= sum;
        rd_cum <= sum;
      end
    end
    s_bin    <= ptr;
    rd_bin   <= s_bin;
    rd_count <= ram_rdata;
  end

  AST_BIN_ASCEND: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_valid)) |-> (rd_bin == $past(rd_bin) + BIN_W'(1))); // R9

  AST_CUM_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_valid)) |-> (rd_cum == $past(rd_cum) + TOT_W'(rd_count))); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done); // R10

  AST_DONE_APART: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> !rd_valid); // R10
endmodule

// File: rtl/code_hist_engine.sv
module code_hist_engine
  import hist_pkg::*;
#(
  parameter int CODE_W = 13,
  parameter int BIN_W  = 10,
  parameter int CNT_W  = 24,
  parameter int TOT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  output logic              busy,
  output logic [TOT_W-1:0]  total_cnt,
  output logic [TOT_W-1:0]  oor_cnt,
  output logic              any_hit,
  output logic [BIN_W-1:0]  min_bin,
  output logic [BIN_W-1:0]  max_bin,
  output logic              rd_valid,
  output logic [BIN_W-1:0]  rd_bin,
  output logic [CNT_W-1:0]  rd_count,
  output logic [TOT_W-1:0]  rd_cum,
  output logic              rd_done
);
  localparam int NBINS = 1 << BIN_W;
  localparam logic [BIN_W-1:0] LAST_BIN = BIN_W'(NBINS - 1);

  eng_state_t state;
  logic [BIN_W-1:0] clr_addr;
  logic             dcnt;

  logic signed [CODE_W-1:0] shv;
  logic             in_range, accept, go;
  logic [BIN_W-1:0] idx;

  logic             upd_we;
  logic [BIN_W-1:0] upd_waddr, upd_raddr, ro_raddr;
  logic [CNT_W-1:0] upd_wdata;

  logic             ram_we;
  logic [BIN_W-1:0] ram_waddr, ram_raddr;
  logic [CNT_W-1:0] ram_wdata, ram_rdata;

  // Bin mapping: drop the LSB, keep signed.
  assign shv      = $signed(in_code) >>> 1;
  assign in_range = !shv[CODE_W-1] && (shv[CODE_W-2:BIN_W] == '0);
  assign idx      = shv[BIN_W-1:0];
  assign accept   = in_valid && (state == ST_ACQ) && !start;
  assign go       = (state == ST_DRAIN) && dcnt && !start;
  assign busy     = (state == ST_CLEAR);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      state    <= ST_CLEAR;
      clr_addr <= '0;
      dcnt     <= 1'b0;
    end else begin
      case (state)
        ST_CLEAR: begin
          clr_addr <= clr_addr + BIN_W'(1);
          if (clr_addr == LAST_BIN) state <= ST_ACQ;
        end
        ST_ACQ: begin
          dcnt <= 1'b0;
          if (stop) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          dcnt <= 1'b1;
          if (dcnt) state <= ST_READ;
        end
        ST_READ:  if (rd_done) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (state == ST_CLEAR) begin
      ram_we    = 1'b1;
      ram_waddr = clr_addr;
      ram_wdata = '0;
    end else begin
      ram_we    = upd_we;
      ram_waddr = upd_waddr;
      ram_wdata = upd_wdata;
    end
    ram_raddr = (state == ST_READ) ? ro_raddr : upd_raddr;
  end

  hist_bin_ram #(.AW(BIN_W), .DW(CNT_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  hist_update #(.BIN_W(BIN_W), .CNT_W(CNT_W)) u_upd (
    .clk(clk), .rst(rst), .flush(start),
    .in_v(accept && in_range), .in_idx(idx),
    .ram_rdata(ram_rdata), .ram_raddr(upd_raddr),
    .we(upd_we), .waddr(upd_waddr), .wdata(upd_wdata)
  );

  hist_stats #(.BIN_W(BIN_W), .TOT_W(TOT_W)) u_stats (
    .clk(clk), .rst(rst), .clr(start),
    .acc(accept), .in_range(in_range), .idx(idx),
    .total(total_cnt), .oor(oor_cnt), .any(any_hit),
    .min_idx(min_bin), .max_idx(max_bin)
  );

  hist_readout #(.BIN_W(BIN_W), .CNT_W(CNT_W), .TOT_W(TOT_W)) u_ro (
    .clk(clk), .rst(rst), .flush(start), .go(go),
    .any(any_hit), .min_idx(min_bin), .max_idx(max_bin),
    .ram_rdata(ram_rdata), .ram_raddr(ro_raddr),
    .rd_valid(rd_valid), .rd_bin(rd_bin), .rd_count(rd_count),
    .rd_cum(rd_cum), .rd_done(rd_done)
  );

  AST_NO_HIST_WRITE_IN_READ: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READ) |-> !upd_we); // R5

  AST_BUSY_NO_STREAM: assert property (@(posedge clk) disable iff (rst)
    busy |-> !rd_valid); // R1
endmodule

// File: tb/code_hist_engine_bench.sv
module code_hist_engine_bench;
  localparam int CLK_P  = 10;
  localparam int CODE_W = 13;
  localparam int BIN_W  = 10;
  localparam int CNT_W  = 6;
  localparam int TOT_W  = 32;
  localparam int NB     = 1 << BIN_W;
  localparam int SATV   = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, stop = 1'b0, in_valid = 1'b0;
  logic [CODE_W-1:0] in_code = '0;
  logic busy, any_hit, rd_valid, rd_done;
  logic [TOT_W-1:0] total_cnt, oor_cnt, rd_cum;
  logic [BIN_W-1:0] min_bin, max_bin, rd_bin;
  logic [CNT_W-1:0] rd_count;

  code_hist_engine #(.CODE_W(CODE_W), .BIN_W(BIN_W), .CNT_W(CNT_W), .TOT_W(TOT_W)) u_code_hist_engine (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .in_valid(in_valid), .in_code(in_code),
    .busy(busy), .total_cnt(total_cnt), .oor_cnt(oor_cnt), .any_hit(any_hit),
    .min_bin(min_bin), .max_bin(max_bin), .rd_valid(rd_valid), .rd_bin(rd_bin),
    .rd_count(rd_count), .rd_cum(rd_cum), .rd_done(rd_done)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  int mdl [NB];
  int m_tot, m_oor, m_min, m_max;
  bit m_any;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bin_of(input int code);
    return code >>> 1;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NB; i++) mdl[i] = 0;
    m_tot = 0; m_oor = 0; m_min = 0; m_max = 0; m_any = 0;
  endtask

  task automatic model_add(input int code);
    int b;
    b = bin_of(code);
    m_tot++;
    if (b < 0 || b >= NB) m_oor++;
    else begin
      if (mdl[b] < SATV) mdl[b]++;
      if (!m_any) begin m_min = b; m_max = b; m_any = 1; end
      else begin
        if (b < m_min) m_min = b;
        if (b > m_max) m_max = b;
      end
    end
  endtask

  // Present one sample during acquisition; gap idle cycles follow.
  task automatic push(input int code, input int gap);
    in_valid = 1'b1;
    in_code  = code[CODE_W-1:0];
    @(negedge clk);
    in_valid = 1'b0;
    model_add(code);
    repeat (gap) @(negedge clk);
  endtask

  task automatic wait_clear(input string req);
    int n = 0;
    while (busy && n < 5000) begin n++; @(negedge clk); end
    chk({req, " busy length"}, n, NB);
  endtask

  task automatic do_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    model_clear();
    wait_clear("R1/R11");
    chk("R1 total after clear", total_cnt, 0);
    chk("R1 oor after clear", oor_cnt, 0);
    chk("R1 any after clear", any_hit, 0);
  endtask

  task automatic check_stats(input string tag);
    chk({tag, " R4 total"}, total_cnt, m_tot);
    chk({tag, " R3 oor"}, oor_cnt, m_oor);
    chk({tag, " R8 any"}, any_hit, m_any);
    if (m_any) begin
      chk({tag, " R8 min"}, min_bin, m_min);
      chk({tag, " R8 max"}, max_bin, m_max);
    end
  endtask

  task automatic do_readout(input string tag);
    int n = 0, t = 0, eb, cum = 0;
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    eb = m_min;
    while (!rd_done && t < 5000) begin
      if (rd_valid) begin
        cum += mdl[eb];
        chk({tag, " R9 bin"}, rd_bin, eb);
        chk({tag, " R9 count"}, rd_count, mdl[eb]);
        chk({tag, " R9 cum"}, rd_cum, cum);
        eb++; n++;
      end
      t++;
      @(negedge clk);
    end
    chk({tag, " R10 done seen"}, rd_done, 1);
    chk({tag, " R9/R10 triples"}, n, m_any ? (m_max - m_min + 1) : 0);
    @(negedge clk);
    chk({tag, " R10 done one cycle"}, rd_done, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed, r, c;
    seed = 32'h1F3A;
    void'($urandom(seed));
    model_clear();
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 1);
    rst = 1'b0;
    // R5: samples during the clear sweep are dropped.
    in_valid = 1'b1;
    in_code  = 13'd40;
    wait_clear("R1 after reset");
    in_valid = 1'b0;
    chk("R5 total after busy samples", total_cnt, 0);
    chk("R1 any after reset", any_hit, 0);

    // Directed: mapping, range edges, burst on one bin.
    push(4, 0); push(5, 1);          // R2 both to bin 2
    push(0, 0); push(1, 0);          // bin 0
    push(2047, 0);                   // R3 top in-range
    push(-1, 0); push(2048, 0); push(-4096, 2); // R3 out of range
    for (int i = 0; i < 10; i++) push(14 + (i & 1), 0); // R6 bin 7 back-to-back
    @(negedge clk);
    check_stats("directed");
    chk("R2 bin2 model", mdl[2], 2);
    chk("R6 bin7 model", mdl[7], 10);
    do_readout("directed");

    // R5: ignored after readout.
    push(100, 0); push(-5, 0);
    m_tot -= 2; m_oor -= 1; mdl[50] -= 1;
    @(negedge clk);
    chk("R5 total after readout", total_cnt, m_tot);
    chk("R5 oor after readout", oor_cnt, m_oor);

    // R10: empty run.
    do_start();
    do_readout("empty");

    // R7: saturation.
    do_start();
    for (int i = 0; i < SATV + 7; i++) push(200, 0);
    push(203, 0);
    @(negedge clk);
    check_stats("sat");
    do_readout("sat R7");

    // R11: restart during acquisition.
    do_start();
    for (int i = 0; i < 20; i++) push(300 + 2 * i, 0);
    do_start();
    push(900, 0); push(960, 0);
    @(negedge clk);
    check_stats("restart R11");
    do_readout("restart R11");

    // Random run.
    do_start();
    for (int i = 0; i < 600; i++) begin
      r = int'($urandom % 100);
      if (r < 5) c = -1 - int'($urandom % 4096);
      else if (r < 10) c = 2048 + int'($urandom % 2048);
      else c = 600 + int'($urandom % 800);
      push(c, int'($urandom % 3));
    end
    @(negedge clk);
    check_stats("random");
    do_readout("random");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule